// File: doc/BRIEF.md
# Shader Issue Hazard Checker

This block sits beside the issue stage of a shader core and watches the instruction stream, at most one issued instruction per clock. For every issue it is told the instruction class, whether the instruction is a multiply-add, its two wait flags (one waits for special-function results, one waits for texture results), its repeat count, whether it is an interpolation input and carries the end-of-input mark, whether it ends the program, and which registers it writes and reads. It does not execute anything. It only decides whether the program obeys the pipeline's timing and synchronisation rules and raises a sticky error bit per kind of violation.

A scoreboard keeps, for every register component, the class of the instruction that last wrote it and the cycle of that write. A cycle counter measures time in issue slots, so a repeated instruction consumes several slots. Reads are checked in the first slot of an instruction and writes are stamped with its last slot. Results from ALU classes must age a fixed number of slots before a read. Results from special-function and texture classes are instead guarded by the wait flags.

Top module: `hzc_hazard_checker`

## Requirements
- R1: While reset is held and right after it, `err_flags` is all zero and `cycle_count` is zero.
- R2: An issue of class 0 to 4 advances `cycle_count` by `iss_rpt`+1. A class 5 issue, or any issue with `iss_end` set, advances it by 1. With `iss_valid` low it holds its value. Class codes: 0 flow, 1 to 3 ALU, 4 special function, 5 texture.
- R3: A read by an ALU-class instruction (1, 2 or 3) of a register last written by an ALU class sets `err_flags` bit 0 when its first slot is less than 3 slots after the writer's last slot.
- R4: Under the same condition, a read by a flow, special-function or texture instruction needs at least 6 slots. Otherwise bit 0 is set.
- R5: When a class 3 instruction has `iss_mad` set, its third source (position 2) needs only 1 slot after an ALU write. Its other sources, and position 2 of an instruction without that combination, keep the 3-slot rule.
- R6: A register written by a special-function instruction may be read only if a special-function wait flag (`iss_ss`) was seen in a later slot than the write. The flag counts only on classes 1 to 4, the reader's own flag included. A violation sets bit 1. These results impose no slot delay.
- R7: A register written by a texture instruction may be read only if a texture wait flag (`iss_sy`) of any class was seen in a later slot than the write. A violation sets bit 2. These results impose no slot delay.
- R8: The first issue after reset, and the first after an end-of-program issue, must carry both wait flags. Otherwise bit 3 is set.
- R9: Two special-function issues in consecutive issues set bit 4. An end-of-program issue between them breaks the pair.
- R10: Among input instructions (`iss_input`) of one program, only the last may carry `iss_eoi`. A later input after a marked one sets bit 5. An end of program whose last input lacks the mark sets bit 6. Programs without inputs raise neither.
- R11: A register component is indexed as 4·number + component. Half registers lie in a separate range after the full ones, so full and half of the same number never interact. A never-written register imposes no rule. An index past its range, full or half, sets bit 7 and is not recorded.
- R12: Every error bit stays set until reset, whatever is issued afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| iss_valid | input | 1 | An instruction is issued this cycle |
| iss_cat | input | 3 | Instruction class, 0 to 5 |
| iss_mad | input | 1 | Instruction is a multiply-add |
| iss_ss | input | 1 | Wait for special-function results |
| iss_sy | input | 1 | Wait for texture results |
| iss_rpt | input | RPT_W | Repeat count |
| iss_input | input | 1 | Instruction is an interpolation input |
| iss_eoi | input | 1 | End-of-input mark |
| iss_end | input | 1 | End of program |
| dst_valid | input | 1 | Instruction writes a register |
| dst_half | input | 1 | Destination is a half register |
| dst_num | input | NUM_W | Destination register number |
| dst_comp | input | 2 | Destination component |
| src_valid | input | 3 | Per-source read enable |
| src_half | input | 3 | Per-source half-register select |
| src_num | input | 3·NUM_W | Source register numbers, source k at bits k·NUM_W |
| src_comp | input | 6 | Source components, source k at bits 2k |
| err_flags | output | 8 | Sticky violation bits |
| cycle_count | output | 32 | Issue slots consumed since reset |

## Verification
A stale or misplaced scoreboard stamp shows up as a wrong delay or sync bit on the first read of that register. The bit appears one clock after the offending issue, so the sweeps read the flags directly after each reader. A slip in the slot counter shows up at once in `cycle_count`, and it also moves every delay boundary by the same amount. This is why the gap sweeps compare the error edge against the exact 1, 3 and 6 slot thresholds. Sequence-state faults, such as a lost first-issue marker or a stale input mark, surface only at the next program boundary, and the end-of-program cases target exactly that.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

  typedef enum logic [2:0] {
    CAT_FLOW = 3'd0,
    CAT_ALU1 = 3'd1,
    CAT_ALU2 = 3'd2,
    CAT_ALU3 = 3'd3,
    CAT_SFU  = 3'd4,
    CAT_TEX  = 3'd5
  } cat_e;

  localparam int ERR_W      = 8;
  localparam int E_DELAY    = 0;
  localparam int E_SFU_WAIT = 1;
  localparam int E_TEX_WAIT = 2;
  localparam int E_FIRST    = 3;
  localparam int E_SFU_PAIR = 4;
  localparam int E_EOI_EARLY = 5;
  localparam int E_EOI_LOST = 6;
  localparam int E_RANGE    = 7;

  localparam int GAP_SHORT = 3;
  localparam int GAP_LONG  = 6;
  localparam int GAP_MAD3  = 1;

  function automatic logic cat_is_alu(input logic [2:0] c);
    return (c == CAT_ALU1) || (c == CAT_ALU2) || (c == CAT_ALU3);
  endfunction

  function automatic logic cat_counts_ss(input logic [2:0] c);
    return cat_is_alu(c) || (c == CAT_SFU);
  endfunction

  function automatic logic cat_repeats(input logic [2:0] c);
    return (c <= CAT_SFU);
  endfunction

endpackage

// File: rtl/hzc_index_map.sv
module hzc_index_map #(
  parameter int NUM_W    = 3,
  parameter int FULL_ENT = 16,
  parameter int HALF_ENT = 8,
  parameter int IDX_W    = 5
) (
  input  logic [NUM_W-1:0] num,
  input  logic [1:0]       comp,
  input  logic             half,
  output logic [IDX_W-1:0] idx,
  output logic             ok
);
  localparam int LIN_W = NUM_W + 2;

  logic [LIN_W-1:0] lin;

  assign lin = {num, comp};

  always_comb begin
    if (half) begin
      ok  = int'(lin) < HALF_ENT;
      idx = ok ? IDX_W'(int'(lin) + FULL_ENT) : '0;
    end else begin
      ok  = int'(lin) < FULL_ENT;
      idx = ok ? IDX_W'(lin) : '0;
    end
  end
endmodule

// File: rtl/hzc_timebase.sv
module hzc_timebase
  import hzc_pkg::*;
#(
  parameter int RPT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [2:0]       cat,
  input  logic             ss,
  input  logic             sy,
  input  logic [RPT_W-1:0] rpt,
  input  logic             endp,
  output logic [31:0]      cyc,
  output logic [31:0]      c_first,
  output logic [31:0]      c_last,
  output logic [31:0]      eff_ss,
  output logic [31:0]      eff_sy
);
  logic [31:0] cyc_q, cyc_d;
  logic [31:0] ss_q, ss_d;
  logic [31:0] sy_q, sy_d;
  logic [31:0] rep_ext;
  logic        ss_hit, sy_hit;

  always_comb begin
    rep_ext = (cat_repeats(cat) && !endp) ? 32'(rpt) : 32'd0;
    c_first = cyc_q + 32'd1;
    c_last  = cyc_q + rep_ext + 32'd1;
    ss_hit  = issue && ss && cat_counts_ss(cat);
    sy_hit  = issue && sy;
    eff_ss  = ss_hit ? c_first : ss_q;
    eff_sy  = sy_hit ? c_first : sy_q;
    cyc_d   = c_last;
    ss_d    = ss_hit ? c_last : ss_q;
    sy_d    = sy_hit ? c_last : sy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      ss_q  <= '0;
      sy_q  <= '0;
    end else if (issue) begin
      cyc_q <= cyc_d;
      ss_q  <= ss_d;
      sy_q  <= sy_d;
    end
  end

  assign cyc = cyc_q;
endmodule

// File: rtl/hzc_scoreboard.sv
module hzc_scoreboard #(
  parameter int ENT   = 24,
  parameter int IDX_W = 5,
  parameter int NRD   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W-1:0]   widx,
  input  logic [2:0]         wcat,
  input  logic [31:0]        wcyc,
  input  logic [NRD*IDX_W-1:0] rd_idx,
  output logic [NRD-1:0]     rd_hit,
  output logic [NRD*3-1:0]   rd_cat,
  output logic [NRD*32-1:0]  rd_cyc
);
  logic [ENT-1:0] vld_q;
  logic [2:0]     cat_q [ENT];
  logic [31:0]    cyc_q [ENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (we) begin
      vld_q[widx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      cat_q[widx] <= wcat;
      cyc_q[widx] <= wcyc;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [IDX_W-1:0] ri;
    assign ri                 = rd_idx[p*IDX_W +: IDX_W];
    assign rd_hit[p]          = vld_q[ri];
    assign rd_cat[p*3 +: 3]   = cat_q[ri];
    assign rd_cyc[p*32 +: 32] = cyc_q[ri];
  end
endmodule

// File: rtl/hzc_operand_check.sv
module hzc_operand_check
  import hzc_pkg::*;
#(
  parameter int POS = 0
) (
  input  logic        chk,
  input  logic [2:0]  rd_cat,
  input  logic        rd_mad,
  input  logic        w_hit,
  input  logic [2:0]  w_cat,
  input  logic [31:0] w_cyc,
  input  logic [31:0] c_first,
  input  logic [31:0] eff_ss,
  input  logic [31:0] eff_sy,
  output logic        bad_delay,
  output logic        bad_ss,
  output logic        bad_sy
);
  logic [3:0]  need;
  logic [32:0] ready_at;
  logic        live;

  always_comb begin
    if ((rd_cat == CAT_FLOW) || (rd_cat == CAT_SFU) || (rd_cat == CAT_TEX)) begin
      need = 4'(GAP_LONG);
    end else if ((rd_cat == CAT_ALU3) && rd_mad && (POS == 2)) begin
      need = 4'(GAP_MAD3);
    end else begin
      need = 4'(GAP_SHORT);
    end
    live      = chk && w_hit;
    ready_at  = {1'b0, w_cyc} + 33'(need);
    bad_delay = live && cat_is_alu(w_cat) && ({1'b0, c_first} < ready_at);
    bad_ss    = live && (w_cat == CAT_SFU) && !(eff_ss > w_cyc);
    bad_sy    = live && (w_cat == CAT_TEX) && !(eff_sy > w_cyc);
  end
endmodule

// File: rtl/hzc_seq_rules.sv
module hzc_seq_rules
  import hzc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       issue,
  input  logic [2:0] cat,
  input  logic       ss,
  input  logic       sy,
  input  logic       inp,
  input  logic       eoi,
  input  logic       endp,
  output logic       bad_first,
  output logic       bad_pair,
  output logic       bad_early,
  output logic       bad_lost
);
  logic first_q, first_d;
  logic sfu_q, sfu_d;
  logic seen_q, seen_d;
  logic mark_q, mark_d;

  always_comb begin
    bad_first = issue && first_q && !(ss && sy);
    bad_pair  = issue && sfu_q && (cat == CAT_SFU);
    bad_early = issue && inp && seen_q && mark_q;
    bad_lost  = issue && endp && seen_q && !mark_q;

    first_d = endp;
    sfu_d   = (cat == CAT_SFU) && !endp;
    seen_d  = seen_q;
    mark_d  = mark_q;
    if (endp) begin
      seen_d = 1'b0;
      mark_d = 1'b0;
    end else if (inp) begin
      seen_d = 1'b1;
      mark_d = eoi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      sfu_q   <= 1'b0;
      seen_q  <= 1'b0;
      mark_q  <= 1'b0;
    end else if (issue) begin
      first_q <= first_d;
      sfu_q   <= sfu_d;
      seen_q  <= seen_d;
      mark_q  <= mark_d;
    end
  end
endmodule

// File: rtl/hzc_hazard_checker.sv
module hzc_hazard_checker
  import hzc_pkg::*;
#(
  parameter int NUM_W     = 3,
  parameter int FULL_REGS = 16,
  parameter int HALF_REGS = 8,
  parameter int RPT_W     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iss_valid,
  input  logic [2:0]         iss_cat,
  input  logic               iss_mad,
  input  logic               iss_ss,
  input  logic               iss_sy,
  input  logic [RPT_W-1:0]   iss_rpt,
  input  logic               iss_input,
  input  logic               iss_eoi,
  input  logic               iss_end,
  input  logic               dst_valid,
  input  logic               dst_half,
  input  logic [NUM_W-1:0]   dst_num,
  input  logic [1:0]         dst_comp,
  input  logic [2:0]         src_valid,
  input  logic [2:0]         src_half,
  input  logic [3*NUM_W-1:0] src_num,
  input  logic [5:0]         src_comp,
  output logic [ERR_W-1:0]   err_flags,
  output logic [31:0]        cycle_count
);
  localparam int NSRC  = 3;
  localparam int ENT   = FULL_REGS + HALF_REGS;
  localparam int IDX_W = $clog2(ENT);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  // register index mapping
  logic [IDX_W-1:0]      dst_idx;
  logic                  dst_ok;
  logic [NSRC*IDX_W-1:0] src_idx;
  logic [NSRC-1:0]       src_ok;

  hzc_index_map #(
    .NUM_W(NUM_W), .FULL_ENT(FULL_REGS), .HALF_ENT(HALF_REGS), .IDX_W(IDX_W)
  ) u_dst_map (
    .num(dst_num), .comp(dst_comp), .half(dst_half), .idx(dst_idx), .ok(dst_ok)
  );

  // slot counter and wait-flag stamps
  logic [31:0] c_first, c_last, eff_ss, eff_sy;

  hzc_timebase #(.RPT_W(RPT_W)) u_time (
    .clk(clk), .rst_n(rst_q), .issue(iss_valid), .cat(iss_cat),
    .ss(iss_ss), .sy(iss_sy), .rpt(iss_rpt), .endp(iss_end),
    .cyc(cycle_count), .c_first(c_first), .c_last(c_last),
    .eff_ss(eff_ss), .eff_sy(eff_sy)
  );

  // last-writer scoreboard
  logic                 sb_we;
  logic [NSRC-1:0]      rd_hit;
  logic [NSRC*3-1:0]    rd_cat;
  logic [NSRC*32-1:0]   rd_cyc;

  assign sb_we = iss_valid && dst_valid && dst_ok && (iss_cat != CAT_FLOW) && !iss_end;

  hzc_scoreboard #(.ENT(ENT), .IDX_W(IDX_W), .NRD(NSRC)) u_sb (
    .clk(clk), .rst_n(rst_q), .we(sb_we), .widx(dst_idx), .wcat(iss_cat),
    .wcyc(c_last), .rd_idx(src_idx), .rd_hit(rd_hit), .rd_cat(rd_cat),
    .rd_cyc(rd_cyc)
  );

  // per-operand checks
  logic [NSRC-1:0] v_delay, v_ss, v_sy;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic chk;
    assign chk = iss_valid && src_valid[s] && src_ok[s] && !iss_end;

    hzc_index_map #(
      .NUM_W(NUM_W), .FULL_ENT(FULL_REGS), .HALF_ENT(HALF_REGS), .IDX_W(IDX_W)
    ) u_map (
      .num(src_num[s*NUM_W +: NUM_W]), .comp(src_comp[2*s +: 2]),
      .half(src_half[s]), .idx(src_idx[s*IDX_W +: IDX_W]), .ok(src_ok[s])
    );

    hzc_operand_check #(.POS(s)) u_chk (
      .chk(chk), .rd_cat(iss_cat), .rd_mad(iss_mad), .w_hit(rd_hit[s]),
      .w_cat(rd_cat[s*3 +: 3]), .w_cyc(rd_cyc[s*32 +: 32]),
      .c_first(c_first), .eff_ss(eff_ss), .eff_sy(eff_sy),
      .bad_delay(v_delay[s]), .bad_ss(v_ss[s]), .bad_sy(v_sy[s])
    );
  end

  // program-order rules
  logic bad_first, bad_pair, bad_early, bad_lost;

  hzc_seq_rules u_seq (
    .clk(clk), .rst_n(rst_q), .issue(iss_valid), .cat(iss_cat),
    .ss(iss_ss), .sy(iss_sy), .inp(iss_input), .eoi(iss_eoi), .endp(iss_end),
    .bad_first(bad_first), .bad_pair(bad_pair), .bad_early(bad_early),
    .bad_lost(bad_lost)
  );

  // sticky error register
  logic [ERR_W-1:0] err_q, err_set, err_d;
  logic             bad_range;

  always_comb begin
    bad_range = iss_valid && ((dst_valid && !dst_ok) || |(src_valid & ~src_ok));
    err_set              = '0;
    err_set[E_DELAY]     = |v_delay;
    err_set[E_SFU_WAIT]  = |v_ss;
    err_set[E_TEX_WAIT]  = |v_sy;
    err_set[E_FIRST]     = bad_first;
    err_set[E_SFU_PAIR]  = bad_pair;
    err_set[E_EOI_EARLY] = bad_early;
    err_set[E_EOI_LOST]  = bad_lost;
    err_set[E_RANGE]     = bad_range;
    err_d                = err_q | err_set;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)         err_q <= '0;
    else if (iss_valid) err_q <= err_d;
  end

  assign err_flags = err_q;
endmodule

// File: rtl/hzc_hazard_checker_sva.sv
module hzc_hazard_checker_sva #(
  parameter int NUM_W     = 3,
  parameter int FULL_REGS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic [2:0]       iss_cat,
  input logic             iss_end,
  input logic             dst_valid,
  input logic             dst_half,
  input logic [NUM_W-1:0] dst_num,
  input logic [7:0]       err_flags,
  input logic [31:0]      cycle_count
);
  AST_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |=> $stable(cycle_count)); // R2

  AST_CYCLE_TEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_cat == 3'd5) |=> (cycle_count == $past(cycle_count) + 32'd1)); // R2

  AST_SFU_PAIR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_cat == 3'd4 && !iss_end) ##1 (iss_valid && iss_cat == 3'd4)
      |=> err_flags[4]); // R9

  AST_DST_RANGE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && dst_valid && !dst_half && (int'(dst_num) * 4 >= FULL_REGS))
      |=> err_flags[7]); // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags != 8'd0) |=> ((err_flags & $past(err_flags)) == $past(err_flags))); // R12
endmodule

bind hzc_hazard_checker hzc_hazard_checker_sva #(
  .NUM_W(NUM_W), .FULL_REGS(FULL_REGS)
) u_sva (
  .clk(clk), .rst_n(rst_q), .iss_valid(iss_valid), .iss_cat(iss_cat),
  .iss_end(iss_end), .dst_valid(dst_valid), .dst_half(dst_half),
  .dst_num(dst_num), .err_flags(err_flags), .cycle_count(cycle_count)
);

// File: tb/hzc_hazard_checker_tb.sv
module hzc_hazard_checker_tb;
  localparam int NUM_W = 3;
  localparam int RPT_W = 3;

  logic             clk;
  logic             rst_n;
  logic             iss_valid;
  logic [2:0]       iss_cat;
  logic             iss_mad, iss_ss, iss_sy;
  logic [RPT_W-1:0] iss_rpt;
  logic             iss_input, iss_eoi, iss_end;
  logic             dst_valid, dst_half;
  logic [NUM_W-1:0] dst_num;
  logic [1:0]       dst_comp;
  logic [2:0]       src_valid, src_half;
  logic [3*NUM_W-1:0] src_num;
  logic [5:0]       src_comp;
  logic [7:0]       err_flags;
  logic [31:0]      cycle_count;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  hzc_hazard_checker #(.NUM_W(NUM_W), .FULL_REGS(16), .HALF_REGS(8), .RPT_W(RPT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_cat(iss_cat),
    .iss_mad(iss_mad), .iss_ss(iss_ss), .iss_sy(iss_sy), .iss_rpt(iss_rpt),
    .iss_input(iss_input), .iss_eoi(iss_eoi), .iss_end(iss_end),
    .dst_valid(dst_valid), .dst_half(dst_half), .dst_num(dst_num),
    .dst_comp(dst_comp), .src_valid(src_valid), .src_half(src_half),
    .src_num(src_num), .src_comp(src_comp), .err_flags(err_flags),
    .cycle_count(cycle_count)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ins(input int cat, input int rpt, input bit ss, input bit sy);
    iss_cat = 3'(cat); iss_rpt = RPT_W'(rpt); iss_ss = ss; iss_sy = sy;
    iss_mad = 0; iss_input = 0; iss_eoi = 0; iss_end = 0;
    dst_valid = 0; dst_half = 0; dst_num = '0; dst_comp = '0;
    src_valid = '0; src_half = '0; src_num = '0; src_comp = '0;
  endtask

  task automatic setdst(input int num, input int comp, input bit half);
    dst_valid = 1; dst_num = NUM_W'(num); dst_comp = 2'(comp); dst_half = half;
  endtask

  task automatic setsrc(input int p, input int num, input int comp, input bit half);
    src_valid[p] = 1'b1; src_half[p] = half;
    src_num[p*NUM_W +: NUM_W] = NUM_W'(num);
    src_comp[2*p +: 2] = 2'(comp);
  endtask

  task automatic go();
    iss_valid = 1'b1;
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic do_reset();
    iss_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // ALU writer to r1.x, gap g slots, then reader
  task automatic alu_gap(input int g, input int rcat, input bit mad, input int pos);
    do_reset();
    ins(1, 0, 1, 1); setdst(1, 0, 0); go();
    if (g >= 2) begin ins(0, g - 2, 0, 0); go(); end
    ins(rcat, 0, 0, 0); iss_mad = mad; setsrc(pos, 1, 0, 0); go();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int exp_cyc;
    ins(0, 0, 0, 0);
    iss_valid = 0;
    rst_n = 0;
    @(negedge clk);
    chk("R1 err in reset", 32'(err_flags), 0);
    chk("R1 cycle in reset", cycle_count, 0);
    do_reset();
    chk("R1 err after reset", 32'(err_flags), 0);
    chk("R1 cycle after reset", cycle_count, 0);

    // R2 slot accounting sweep
    exp_cyc = 0;
    for (int c = 0; c < 6; c++) begin
      for (int r = 0; r < 8; r++) begin
        ins(c, r, 1, 1); go();
        exp_cyc += (c <= 4) ? r + 1 : 1;
        chk("R2 cycle advance", cycle_count, 32'(exp_cyc));
      end
    end
    repeat (4) @(negedge clk);
    chk("R2 idle hold", cycle_count, 32'(exp_cyc));
    ins(0, 5, 1, 1); iss_end = 1; go();
    exp_cyc += 1;
    chk("R2 end ignores repeat", cycle_count, 32'(exp_cyc));

    // R3 / R4 gap sweep over reader classes
    for (int rc = 0; rc < 6; rc++) begin
      for (int g = 1; g <= 8; g++) begin
        int need;
        bit alu;
        alu  = (rc >= 1 && rc <= 3);
        need = alu ? 3 : 6;
        alu_gap(g, rc, 0, 0);
        chk(alu ? "R3 alu->alu gap" : "R4 alu->long gap", 32'(err_flags),
            (g < need) ? 32'h01 : 32'h00);
      end
    end

    // R5 multiply-add third source
    for (int p = 0; p < 3; p++) begin
      for (int g = 1; g <= 4; g++) begin
        int need;
        need = (p == 2) ? 1 : 3;
        alu_gap(g, 3, 1, p);
        chk("R5 mad operand gap", 32'(err_flags), (g < need) ? 32'h01 : 32'h00);
      end
    end
    alu_gap(2, 3, 0, 2);
    chk("R5 cat3 without mad", 32'(err_flags), 32'h01);
    alu_gap(2, 2, 1, 2);
    chk("R5 mad flag on cat2", 32'(err_flags), 32'h01);

    // R6 special-function wait
    do_reset();
    ins(4, 0, 1, 1); setdst(2, 1, 0); go();
    ins(0, 6, 0, 0); go();
    ins(2, 0, 0, 0); setsrc(1, 2, 1, 0); go();
    chk("R6 no wait", 32'(err_flags), 32'h02);
    do_reset();
    ins(4, 0, 1, 1); setdst(2, 1, 0); go();
    ins(0, 0, 1, 0); go();
    ins(2, 0, 0, 0); setsrc(1, 2, 1, 0); go();
    chk("R6 flow wait ignored", 32'(err_flags), 32'h02);
    do_reset();
    ins(4, 0, 1, 1); setdst(2, 1, 0); go();
    ins(1, 0, 1, 0); go();
    ins(2, 0, 0, 0); setsrc(1, 2, 1, 0); go();
    chk("R6 alu wait", 32'(err_flags), 32'h00);
    do_reset();
    ins(4, 0, 1, 1); setdst(2, 1, 0); go();
    ins(2, 0, 1, 0); setsrc(0, 2, 1, 0); go();
    chk("R6 own wait no delay", 32'(err_flags), 32'h00);

    // R7 texture wait
    do_reset();
    ins(5, 0, 1, 1); setdst(3, 2, 0); go();
    ins(0, 0, 0, 1); go();
    ins(2, 0, 0, 0); setsrc(0, 3, 2, 0); go();
    chk("R7 flow sy counts", 32'(err_flags), 32'h00);
    do_reset();
    ins(5, 0, 1, 1); setdst(3, 2, 0); go();
    ins(0, 6, 0, 0); go();
    ins(2, 0, 1, 0); setsrc(0, 3, 2, 0); go();
    chk("R7 missing sy", 32'(err_flags), 32'h04);
    do_reset();
    ins(5, 0, 1, 1); setdst(3, 2, 0); go();
    ins(1, 0, 0, 1); setsrc(2, 3, 2, 0); go();
    chk("R7 own sy no delay", 32'(err_flags), 32'h00);

    // R8 first-issue flags
    do_reset(); ins(1, 0, 1, 0); go();
    chk("R8 ss only", 32'(err_flags), 32'h08);
    do_reset(); ins(1, 0, 0, 1); go();
    chk("R8 sy only", 32'(err_flags), 32'h08);
    do_reset(); ins(1, 0, 1, 1); go(); ins(1, 0, 0, 0); go();
    chk("R8 both then plain", 32'(err_flags), 32'h00);
    do_reset(); ins(1, 0, 1, 1); go();
    ins(0, 0, 0, 0); iss_end = 1; go();
    ins(1, 0, 1, 0); go();
    chk("R8 after end", 32'(err_flags), 32'h08);

    // R9 back-to-back special function
    do_reset(); ins(4, 0, 1, 1); go(); ins(4, 0, 0, 0); go();
    chk("R9 pair", 32'(err_flags), 32'h10);
    do_reset(); ins(4, 0, 1, 1); go(); ins(0, 0, 0, 0); go(); ins(4, 0, 0, 0); go();
    chk("R9 separated", 32'(err_flags), 32'h00);
    do_reset(); ins(4, 0, 1, 1); go();
    ins(0, 0, 0, 0); iss_end = 1; go();
    ins(4, 0, 1, 1); go();
    chk("R9 across end", 32'(err_flags), 32'h00);

    // R10 end-of-input mark
    do_reset();
    ins(2, 0, 1, 1); iss_input = 1; go();
    ins(2, 0, 0, 0); iss_input = 1; iss_eoi = 1; go();
    ins(0, 0, 0, 0); iss_end = 1; go();
    chk("R10 mark on last", 32'(err_flags), 32'h00);
    do_reset();
    ins(2, 0, 1, 1); iss_input = 1; iss_eoi = 1; go();
    ins(2, 0, 0, 0); iss_input = 1; iss_eoi = 1; go();
    chk("R10 mark early", 32'(err_flags), 32'h20);
    do_reset();
    ins(2, 0, 1, 1); iss_input = 1; go();
    ins(0, 0, 0, 0); iss_end = 1; go();
    chk("R10 mark lost", 32'(err_flags), 32'h40);
    do_reset();
    ins(0, 0, 1, 1); go();
    ins(0, 0, 0, 0); iss_end = 1; go();
    chk("R10 no inputs", 32'(err_flags), 32'h00);

    // R11 unwritten, full/half separation, range
    do_reset();
    ins(1, 0, 1, 1); go();
    ins(5, 0, 0, 0); setsrc(2, 3, 3, 0); go();
    chk("R11 unwritten", 32'(err_flags), 32'h00);
    do_reset();
    ins(1, 0, 1, 1); setdst(0, 0, 0); go();
    ins(1, 0, 0, 0); setsrc(0, 0, 0, 1); go();
    chk("R11 half separate", 32'(err_flags), 32'h00);
    ins(1, 0, 0, 0); setsrc(0, 0, 0, 0); go();
    chk("R11 full hit", 32'(err_flags), 32'h01);
    do_reset();
    ins(1, 0, 1, 1); setdst(4, 0, 0); go();
    chk("R11 full dst range", 32'(err_flags), 32'h80);
    do_reset();
    ins(1, 0, 1, 1); setsrc(1, 2, 0, 1); go();
    chk("R11 half src range", 32'(err_flags), 32'h80);
    do_reset();
    ins(1, 0, 1, 1); setsrc(1, 1, 3, 1); setdst(3, 3, 0); go();
    chk("R11 top indices", 32'(err_flags), 32'h00);

    // R12 sticky bits
    do_reset();
    ins(1, 0, 1, 1); setdst(5, 0, 0); go();
    for (int k = 0; k < 5; k++) begin ins(0, 0, 1, 1); go(); end
    chk("R12 held", 32'(err_flags), 32'h80);
    ins(1, 0, 0, 0); setdst(1, 1, 0); go();
    ins(1, 0, 0, 0); setsrc(0, 1, 1, 0); go();
    chk("R12 accumulate", 32'(err_flags), 32'h81);
    repeat (3) @(negedge clk);
    chk("R12 idle held", 32'(err_flags), 32'h81);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule